// File: doc/BRIEF.md
# RTC Calendar Alarm Match Unit

This block watches the calendar produced by an external time counter and raises an interrupt when the calendar agrees with a programmed alarm. There are six alarm fields: seconds, minutes, hours, date, month and day of week. Each one holds a BCD value in bits 6:0 and a compare-enable flag in bit 7. A field whose flag is clear takes no part in the comparison, so 00h switches that field off. The comparison is made only on the single clock cycle in which the time counter pulses `tick`. The alarm therefore fires once for each time advance, and a calendar that simply stays equal to the alarm does not retrigger it.

Software uses a small register port to program the alarm fields, the control register and the status register. Control bit 5 arms the alarm. Control bit 7 chooses between two interrupt modes:
- **Held mode:** the interrupt stays low until software clears the status flag.
- **Pulsed mode:** the interrupt drops for a fixed number of cycles on every match, and nobody needs to service the flag.

A three-state machine drives the interrupt output. Its states are `S_IDLE`, `S_HELD` and `S_PULSE`, and its transitions are:
- **arm_held:** a hit while the mode bit is 0 enters `S_HELD`.
- **arm_pulse:** a hit while the mode bit is 1 enters `S_PULSE` and reloads the width counter.
- **release:** a status-clear write with no hit in the same cycle moves `S_HELD` to `S_IDLE`.
- **expire:** the width counter reaching zero with no hit moves `S_PULSE` to `S_IDLE`.

A hit is taken from any state.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, irq_n is 1, alarm_flag is 0, and every register reads back as 00h.
- R2: The register addresses are 0 = seconds, 1 = minutes, 2 = hours, 3 = date, 4 = month, 5 = day of week, 6 = control and 7 = status. Registers 0 to 6 read back the last byte written to them. Status reads as {7'b0, alarm_flag}. A status write with bit 0 = 0 clears the flag, and a status write with bit 0 = 1 has no effect.
- R3: An alarm field whose bit 7 is 0 is ignored. Its value has no effect on whether the alarm fires.
- R4: A hit requires every enabled field's bits 6:0 to equal the matching calendar input. When no field is enabled, every qualifying tick is a hit.
- R5: Matching is evaluated only in cycles where tick = 1. A calendar equal to the alarm with tick = 0, including just after the alarm registers are written, leaves irq_n and alarm_flag unchanged.
- R6: With control bit 5 = 0, no hit occurs.
- R7: In held mode (control bit 7 = 0), a hit sets alarm_flag and drives irq_n low from the cycle after the tick edge. irq_n stays low until the status flag is cleared.
- R8: A status clear drops alarm_flag and raises irq_n at the same edge. If a hit occurs in the same cycle, the hit wins.
- R9: In pulsed mode (control bit 7 = 1), each hit sets alarm_flag and drives irq_n low for exactly PULSE_CYC cycles. A hit during a pulse restarts the pulse. Later pulses occur without the flag being cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| tick | input | 1 | One-cycle pulse when the calendar advances |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 7 | Current hours, BCD |
| cal_date | input | 7 | Current date, BCD |
| cal_month | input | 7 | Current month, BCD |
| cal_dow | input | 7 | Current day of week |
| irq_n | output | 1 | Active-low alarm interrupt |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The assertions assume that `tick` is a clean one-cycle strobe. They also assume that software clears the status flag only through the status address, and that the calendar inputs are stable around the sampling edge. The stimulus drives every input at the falling edge and raises `tick` for one cycle at a time, though ticks may fall on back-to-back cycles. The calendar inputs are usually copied from the programmed alarm fields so that hits and near-misses are common. A cycle-level model in the bench tracks the flag and the interrupt state and compares them on every cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int NFIELD    = 6;
    localparam int ADDR_W    = 3;
    localparam int ADDR_CTRL = 6;
    localparam int ADDR_STAT = 7;
    localparam int CTRL_ARM  = 5;
    localparam int CTRL_MODE = 7;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HELD  = 2'd1,
        S_PULSE = 2'd2
    } irq_state_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              hit,
    output logic [7:0]        rdata,
    output logic [7:0]        alm [NFIELD],
    output logic [7:0]        ctrl,
    output logic              flag,
    output logic              stat_clr
);
    assign stat_clr = wr_en && (addr == ADDR_W'(ADDR_STAT)) && !wdata[0];

    for (genvar i = 0; i < NFIELD; i++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm[i] <= '0;
            else if (wr_en && addr == ADDR_W'(i))
                alm[i] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && addr == ADDR_W'(ADDR_CTRL))
            ctrl <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (hit)
            flag <= 1'b1;
        else if (stat_clr)
            flag <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_STAT))
            rdata = {7'b0, flag};
        else if (addr == ADDR_W'(ADDR_CTRL))
            rdata = ctrl;
        else if (int'(addr) < NFIELD)
            rdata = alm[int'(addr)];
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic [7:0] alm [NFIELD],
    input  logic [6:0] cal [NFIELD],
    output logic       match
);
    logic [NFIELD-1:0] field_ok;

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign field_ok[i] = !alm[i][7] || (alm[i][6:0] == cal[i]);
    end

    assign match = &field_ok;
endmodule

// File: rtl/rtc_alarm_irq_fsm.sv
module rtc_alarm_irq_fsm
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       pulsed,
    input  logic       stat_clr,
    output irq_state_t st,
    output logic       irq_n
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    irq_state_t        st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (hit) begin
            st_nx  = pulsed ? S_PULSE : S_HELD;
            cnt_nx = CNT_W'(PULSE_CYC - 1);
        end else begin
            unique case (st)
                S_IDLE:  ;
                S_HELD:  if (stat_clr) st_nx = S_IDLE;
                S_PULSE: begin
                    if (cnt == '0) st_nx = S_IDLE;
                    else           cnt_nx = cnt - 1'b1;
                end
                default: st_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        irq_n = (st == S_IDLE);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              tick,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [6:0]        cal_hour,
    input  logic [6:0]        cal_date,
    input  logic [6:0]        cal_month,
    input  logic [6:0]        cal_dow,
    output logic              irq_n,
    output logic              alarm_flag
);
    logic [7:0] alm [NFIELD];
    logic [6:0] cal [NFIELD];
    logic [7:0] ctrl_q;
    logic       match, hit, stat_clr;
    irq_state_t st;

    assign cal[0] = cal_sec;
    assign cal[1] = cal_min;
    assign cal[2] = cal_hour;
    assign cal[3] = cal_date;
    assign cal[4] = cal_month;
    assign cal[5] = cal_dow;

    assign hit = tick && ctrl_q[CTRL_ARM] && match;

    rtc_alarm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit(hit), .rdata(rdata), .alm(alm), .ctrl(ctrl_q),
        .flag(alarm_flag), .stat_clr(stat_clr)
    );

    rtc_alarm_cmp u_cmp (.alm(alm), .cal(cal), .match(match));

    rtc_alarm_irq_fsm #(.PULSE_CYC(PULSE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .pulsed(ctrl_q[CTRL_MODE]),
        .stat_clr(stat_clr), .st(st), .irq_n(irq_n)
    );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       armed,
    input logic       hit,
    input logic       clr,
    input logic       irq_n,
    input logic       alarm_flag,
    input irq_state_t st
);
    localparam int RUN_W = $clog2(PULSE_CYC + 1) + 1;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run <= '0;
        else if (hit)              run <= '0;
        else if (st == S_PULSE)    run <= run + 1'b1;
        else                       run <= '0;
    end

    p_fall_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(tick));

    p_fall_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(armed));

    p_flag_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag && !irq_n);

    p_held_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HELD && !clr) |=> !irq_n);

    p_clear_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HELD && clr && !hit) |=> irq_n && !alarm_flag);

    p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PULSE) |-> (int'(run) < PULSE_CYC));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(ctrl_q[5]), .hit(hit),
    .clr(stat_clr), .irq_n(irq_n), .alarm_flag(alarm_flag), .st(st)
);

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
    localparam int P = 4;

    logic       clk = 0, rst_n = 0;
    logic       wr_en = 0, tick = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic [6:0] cal [6];
    logic       irq_n, alarm_flag;

    int n_run = 0, n_fail = 0;

    logic [7:0] m_reg [8];
    logic       m_flag;
    int         m_st, m_cnt;

    always #10 clk = ~clk;

    rtc_alarm_match #(.PULSE_CYC(P)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick(tick), .cal_sec(cal[0]), .cal_min(cal[1]),
        .cal_hour(cal[2]), .cal_date(cal[3]), .cal_month(cal[4]),
        .cal_dow(cal[5]), .irq_n(irq_n), .alarm_flag(alarm_flag)
    );

    function automatic bit m_match();
        for (int i = 0; i < 6; i++)
            if (m_reg[i][7] && m_reg[i][6:0] != cal[i]) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        return (a == 3'd7) ? {7'b0, m_flag} : m_reg[a];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit hit, clr;
        hit = tick && m_reg[6][5] && m_match();
        clr = wr_en && addr == 3'd7 && !wdata[0];
        if (hit) begin
            m_st  = m_reg[6][7] ? 2 : 1;
            m_cnt = P - 1;
        end else if (m_st == 1 && clr) m_st = 0;
        else if (m_st == 2) begin
            if (m_cnt == 0) m_st = 0; else m_cnt--;
        end
        if (hit) m_flag = 1; else if (clr) m_flag = 0;
        if (wr_en && addr != 3'd7) m_reg[addr] = wdata;
    endtask

    task automatic cyc(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({req, " irq_n"}, {7'b0, irq_n}, {7'b0, (m_st == 0)});
        check({req, " alarm_flag"}, {7'b0, alarm_flag}, {7'b0, m_flag});
        wr_en = 0; tick = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        cyc("R2 write");
    endtask

    task automatic set_cal(input logic [6:0] s, m, h, d, mo, w);
        cal[0] = s; cal[1] = m; cal[2] = h; cal[3] = d; cal[4] = mo; cal[5] = w;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
        m_flag = 0; m_st = 0; m_cnt = 0;
        set_cal(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        check("R1 flag", {7'b0, alarm_flag}, 8'h00);
        rst_n = 1;
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a); #1;
            check("R1 reg", rdata, 8'h00);
        end

        // R2 readback
        for (int a = 0; a < 7; a++) wr(3'(a), 8'(8'h11 * (a + 1)));
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a); #1;
            check("R2 readback", rdata, m_read(3'(a)));
        end

        // Held-mode single alarm: 11:30 Jan 1, seconds/dow off
        wr(0, 8'h00); wr(1, 8'hB0); wr(2, 8'h91); wr(3, 8'h81); wr(4, 8'h81); wr(5, 8'h00);
        wr(6, 8'h20);
        set_cal(7'h59, 7'h29, 7'h11, 7'h01, 7'h01, 7'h03);
        tick = 1; cyc("R4 near miss");
        check("R4 no hit before rollover", {7'b0, irq_n}, 8'h01);
        set_cal(7'h00, 7'h30, 7'h11, 7'h01, 7'h01, 7'h03);
        cyc("R5 static no tick");
        check("R5 no fire without tick", {7'b0, irq_n}, 8'h01);
        tick = 1; cyc("R7 hit");
        check("R7 irq low", {7'b0, irq_n}, 8'h00);
        check("R7 flag set", {7'b0, alarm_flag}, 8'h01);
        repeat (10) cyc("R7 hold");
        check("R7 still low", {7'b0, irq_n}, 8'h00);
        wr(7, 8'h01);
        check("R2 write one no effect", {7'b0, alarm_flag}, 8'h01);
        wr(7, 8'h00);
        check("R8 released", {7'b0, irq_n}, 8'h01);
        check("R8 flag cleared", {7'b0, alarm_flag}, 8'h00);
        // R3: change disabled seconds/dow field values, still hits
        wr(0, 8'h45); wr(5, 8'h06);
        tick = 1; cyc("R3 disabled ignored");
        check("R3 hit despite disabled mismatch", {7'b0, irq_n}, 8'h00);
        // R8 clear and hit same edge: hit wins
        tick = 1; wr_en = 1; addr = 7; wdata = 0; cyc("R8 coincident");
        check("R8 hit wins", {7'b0, alarm_flag}, 8'h01);
        wr(7, 8'h00);
        // R6 disarmed
        wr(6, 8'h00);
        tick = 1; cyc("R6 disarmed");
        check("R6 no hit", {7'b0, irq_n}, 8'h01);

        // R9 pulsed: seconds == 30 only
        wr(0, 8'hB0); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00); wr(5, 8'h00);
        wr(6, 8'hA0);
        cal[0] = 7'h30;
        tick = 1; cyc("R9 pulse");
        begin
            int low = 0;
            for (int k = 0; k < P + 3; k++) begin
                if (!irq_n) low++;
                cyc("R9 pulse run");
            end
            check("R9 width", 8'(low), 8'(P));
        end
        tick = 1; cyc("R9 second pulse without clear");
        check("R9 repeat", {7'b0, irq_n}, 8'h00);
        // R4 all fields disabled: every tick hits
        wr(0, 8'h00); wr(7, 8'h00);
        repeat (P + 1) cyc("R4 idle");
        tick = 1; cyc("R4 vacuous");
        check("R4 all disabled fires", {7'b0, irq_n}, 8'h00);

        // Random phase
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) begin
                wr_en = 1;
                addr  = 3'($urandom_range(7));
                wdata = 8'($urandom);
                if (addr < 6) wdata[7] = ($urandom_range(2) != 0);
                if (addr == 7) wdata[0] = ($urandom_range(1) == 1);
                if (addr == 6) wdata[5] = ($urandom_range(3) != 0);
            end else addr = 3'($urandom_range(7));
            tick = ($urandom_range(2) == 0);
            for (int i = 0; i < 6; i++)
                cal[i] = ($urandom_range(3) != 0) ? m_reg[i][6:0] : 7'($urandom);
            begin
                logic [2:0] ra;
                ra = addr;
                cyc("R4 R7 R9 random");
                addr = ra; #1;
                check("R2 random read", rdata, m_read(ra));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule